// File: doc/BRIEF.md
# Two-Channel Coincidence Pulse Processor

This block sits behind the comparators of a two-channel particle detector. Each raw comparator level is synchronised to the clock. Its rising edge fires a one-shot that produces a fixed-width discriminator pulse. The two discriminator pulses are then combined in two ways. Their AND marks a coincidence, where both channels are active at once. Their XOR marks an anti-coincidence, where exactly one channel is active. Each of these two results fires its own longer one-shot, slow enough for a host GPIO to sample. Each channel also fires a very long one-shot that drives a visible indicator LED.

A small select register picks one of five sources for a registered timing output: the coincidence event, the anti-coincidence event, discriminator 1, discriminator 2, or an external timepulse input. An external timestamper captures the rising edge of this output, and an inverted copy is driven next to it.

The three durations are given in nanoseconds. Each is turned into a cycle count from the clock-frequency parameter as ceil(ns × Hz / 1e9), with a minimum of one cycle. None of the pins carries a data stream. They are plain levels and a plain register write strobe, so they take no valid/ready handshake and nothing can push back.

Top module: `coinc_top`

## Requirements
- R1: While `rst` is high at a clock edge, every output is low after that edge, including `tmeas_n_o`. The select register is cleared to code 0.
- R2: A rising edge on `ch_raw[c]` drives `disc_o[c]` high after the third clock edge, counted from the first edge at which the high level is sampled. The pulse lasts SHAPE cycles.
- R3: A one-shot ignores rising edges of its trigger while its pulse is still active. It does not extend or restart.
- R4: When both discriminator pulses are high together, `evt_and_o` goes high one cycle after the overlap begins and stays high for EVENT cycles. Pulses that do not overlap produce no coincidence event.
- R5: When exactly one discriminator pulse is high, `evt_xor_o` goes high one cycle after that condition begins and stays high for EVENT cycles. A simultaneous pair does not fire it.
- R6: Each `led_o[c]` goes high one cycle after its discriminator pulse rises and stays high for LED cycles.
- R7: `tmeas_o` is registered and follows the selected source one cycle later. The select codes are: 0 for the coincidence event, 1 for the anti-coincidence event, 2 for discriminator 1, 3 for discriminator 2, and 4 for the synchronised timepulse. The timepulse passes through the same two-flop synchroniser as the channels.
- R8: Select codes 5, 6 and 7 drive `tmeas_o` low. A value written with `sel_wr_en` is held from the next edge, and `tmeas_o` reflects it after the edge after that.
- R9: When reset is not active, `tmeas_n_o` is always the complement of `tmeas_o`.
- R10: SHAPE, EVENT and LED are the cycle counts ceil(ns × CLK_HZ / 1e9), each at least 1. With a 100 MHz clock and 100 ns / 1000 ns / 2000 ns, they are 10, 100 and 200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_raw | input | 2 | Raw comparator levels, bit c is channel c+1 |
| tpulse_in | input | 1 | External timepulse level |
| sel_wr_en | input | 1 | Write strobe for the select register |
| sel_wr_data | input | 3 | Select code written on the strobe |
| disc_o | output | 2 | Shaped discriminator pulses |
| evt_and_o | output | 1 | Stretched coincidence event |
| evt_xor_o | output | 1 | Stretched anti-coincidence event |
| led_o | output | 2 | Long stretched indicator drive per channel |
| tmeas_o | output | 1 | Selected timing signal, registered |
| tmeas_n_o | output | 1 | Inverted copy of the timing signal |

## Verification
The latencies are counted from the first edge at which a raw level is sampled high. A discriminator pulse is due three edges later. Its LED drive and any event it causes are due four edges later, or one edge after an overlap begins. The timing output lags its source by one further edge, and a select write shows there two edges after the strobe. The driver works each expected level out against its own cycle counter from these latencies and the durations. It queues a (cycle, mask, value) item for the first and last active cycle and for the first idle cycle of each pulse. The monitor compares each item only at the falling edge of exactly that cycle, so an output that is one cycle early, late, short or long is caught.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

  localparam int NCH = 2;

  typedef enum logic [2:0] {
    SRC_AND = 3'd0,
    SRC_XOR = 3'd1,
    SRC_CH1 = 3'd2,
    SRC_CH2 = 3'd3,
    SRC_TP  = 3'd4
  } tsrc_e;

  // Cycles covering a duration: ceil(ns * hz / 1e9), never below one.
  function automatic int unsigned ns_to_cycles(input longint unsigned hz,
                                               input longint unsigned ns);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 64'd0) return 32'd1;
    return 32'(c);
  endfunction

endpackage

// File: rtl/coinc_sync.sv
module coinc_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/coinc_oneshot.sv
module coinc_oneshot #(
  parameter int unsigned LEN = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse
);
  localparam int CW = $clog2(LEN + 1);

  logic          trig_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise = trig & ~trig_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      trig_q <= trig;
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - CW'(1);
      end else if (rise) begin
        cnt_q <= CW'(LEN);
      end
    end
  end

  assign pulse = (cnt_q != '0);
endmodule

// File: rtl/coinc_tsel.sv
module coinc_tsel
  import coinc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] wr_data,
  input  logic       src_and,
  input  logic       src_xor,
  input  logic       src_ch1,
  input  logic       src_ch2,
  input  logic       src_tp,
  output tsrc_e      sel,
  output logic       tm,
  output logic       tm_n
);
  tsrc_e sel_q;
  logic  pick;
  logic  tm_q;
  logic  tmn_q;

  always_comb begin
    case (sel_q)
      SRC_AND: pick = src_and;
      SRC_XOR: pick = src_xor;
      SRC_CH1: pick = src_ch1;
      SRC_CH2: pick = src_ch2;
      SRC_TP:  pick = src_tp;
      default: pick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SRC_AND;
      tm_q  <= 1'b0;
      tmn_q <= 1'b0;
    end else begin
      if (wr_en) sel_q <= tsrc_e'(wr_data);
      tm_q  <= pick;
      tmn_q <= ~pick;
    end
  end

  assign sel  = sel_q;
  assign tm   = tm_q;
  assign tm_n = tmn_q;
endmodule

// File: rtl/coinc_top.sv
module coinc_top
  import coinc_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 100_000_000,
  parameter longint unsigned SHAPE_NS = 100,
  parameter longint unsigned EVENT_NS = 1_000,
  parameter longint unsigned LED_NS   = 100_000_000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] ch_raw,
  input  logic           tpulse_in,
  input  logic           sel_wr_en,
  input  logic [2:0]     sel_wr_data,
  output logic [NCH-1:0] disc_o,
  output logic           evt_and_o,
  output logic           evt_xor_o,
  output logic [NCH-1:0] led_o,
  output logic           tmeas_o,
  output logic           tmeas_n_o
);
  localparam int unsigned SHAPE_CYC = ns_to_cycles(CLK_HZ, SHAPE_NS);
  localparam int unsigned EVENT_CYC = ns_to_cycles(CLK_HZ, EVENT_NS);
  localparam int unsigned LED_CYC   = ns_to_cycles(CLK_HZ, LED_NS);

  logic [NCH:0]   sync_q;
  logic [NCH-1:0] disc;
  logic           tp_s;
  logic           both_on;
  logic           one_on;
  logic           evt_and;
  logic           evt_xor;
  tsrc_e          sel_q;

  coinc_sync #(.W(NCH + 1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({tpulse_in, ch_raw}),
    .q   (sync_q)
  );

  assign tp_s = sync_q[NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    coinc_oneshot #(.LEN(SHAPE_CYC)) u_disc (
      .clk   (clk),
      .rst   (rst),
      .trig  (sync_q[c]),
      .pulse (disc[c])
    );
    coinc_oneshot #(.LEN(LED_CYC)) u_led (
      .clk   (clk),
      .rst   (rst),
      .trig  (disc[c]),
      .pulse (led_o[c])
    );
  end

  assign both_on = &disc;
  assign one_on  = ^disc;

  coinc_oneshot #(.LEN(EVENT_CYC)) u_evt_and (
    .clk   (clk),
    .rst   (rst),
    .trig  (both_on),
    .pulse (evt_and)
  );

  coinc_oneshot #(.LEN(EVENT_CYC)) u_evt_xor (
    .clk   (clk),
    .rst   (rst),
    .trig  (one_on),
    .pulse (evt_xor)
  );

  coinc_tsel u_tsel (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (sel_wr_en),
    .wr_data (sel_wr_data),
    .src_and (evt_and),
    .src_xor (evt_xor),
    .src_ch1 (disc[0]),
    .src_ch2 (disc[1]),
    .src_tp  (tp_s),
    .sel     (sel_q),
    .tm      (tmeas_o),
    .tm_n    (tmeas_n_o)
  );

  assign disc_o    = disc;
  assign evt_and_o = evt_and;
  assign evt_xor_o = evt_xor;
endmodule

// File: rtl/coinc_chk.sv
module coinc_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] raw,
  input logic [1:0] disc,
  input logic       evt_and,
  input logic       evt_xor,
  input logic [1:0] led,
  input logic       tm,
  input logic       tm_n,
  input logic [2:0] sel
);
  // R1: reset clears every output
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (disc == 2'b00 && !evt_and && !evt_xor && led == 2'b00 && !tm && !tm_n));

  // R2: a discriminator pulse starts only from a sampled raw high
  a_r2_disc_from_raw: assert property (@(posedge clk) disable iff (rst)
    $rose(disc[0]) |-> $past(raw[0], 3));

  // R4: coincidence event only when both pulses were high
  a_r4_and_needs_both: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_and) |-> $past(disc[0] && disc[1]));

  // R5: anti-coincidence event only when exactly one pulse was high
  a_r5_xor_needs_one: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_xor) |-> $past(disc[0] ^ disc[1]));

  // R7: code 0 routes the coincidence event one cycle later
  a_r7_and_route: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd0) |=> (tm == $past(evt_and)));

  // R8: unused codes hold the timing output low
  a_r8_unused_low: assert property (@(posedge clk) disable iff (rst)
    (sel >= 3'd5) |=> !tm);

  // R9: inverted copy once out of reset
  a_r9_inverted: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (tm_n != tm));
endmodule

bind coinc_top coinc_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .raw     (ch_raw),
  .disc    (disc_o),
  .evt_and (evt_and_o),
  .evt_xor (evt_xor_o),
  .led     (led_o),
  .tm      (tmeas_o),
  .tm_n    (tmeas_n_o),
  .sel     (sel_q)
);

// File: tb/coinc_top_tb_top.sv
module coinc_top_tb_top;
  // 100 MHz clock; durations chosen so SH=10, EV=100, LD=200 cycles (R10)
  localparam int SH = 10;
  localparam int EV = 100;
  localparam int LD = 200;

  localparam logic [7:0] D1 = 8'h01, D2 = 8'h02, AN = 8'h04, XO = 8'h08;
  localparam logic [7:0] L1 = 8'h10, L2 = 8'h20, TM = 8'h40, TN = 8'h80;

  typedef struct {
    int         cyc;
    logic [7:0] mask;
    logic [7:0] val;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] raw;
  logic       tp;
  logic       wen;
  logic [2:0] wdat;
  logic [1:0] disc;
  logic       evt_and;
  logic       evt_xor;
  logic [1:0] led;
  logic       tm;
  logic       tmn;
  logic [7:0] obs;

  int   cyc = 0;
  int   t0 = 0;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  exp_t q[$];
  exp_t mon_e;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  coinc_top #(
    .CLK_HZ   (100_000_000),
    .SHAPE_NS (100),
    .EVENT_NS (1_000),
    .LED_NS   (2_000)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .ch_raw      (raw),
    .tpulse_in   (tp),
    .sel_wr_en   (wen),
    .sel_wr_data (wdat),
    .disc_o      (disc),
    .evt_and_o   (evt_and),
    .evt_xor_o   (evt_xor),
    .led_o       (led),
    .tmeas_o     (tm),
    .tmeas_n_o   (tmn)
  );

  assign obs = {tmn, tm, led, evt_xor, evt_and, disc};

  // monitor: compares each queued item in exactly its cycle
  always @(negedge clk) begin
    while (q.size() != 0 && q[0].cyc <= cyc) begin
      mon_e = q.pop_front();
      n_vec++;
      if ((obs & mon_e.mask) !== (mon_e.val & mon_e.mask)) begin
        n_bad++;
        $display("FAIL %s at cycle %0d: actual %b expected %b (mask %b)",
                 mon_e.tag, cyc, obs & mon_e.mask, mon_e.val & mon_e.mask, mon_e.mask);
      end
    end
  end

  task automatic at(input int dc, input logic [7:0] m, input logic [7:0] v, input string tag);
    exp_t e;
    e.cyc = t0 + dc; e.mask = m; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] v);
    wen = 1'b1; wdat = v;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    rst = 1'b1; raw = 2'b00; tp = 1'b0; wen = 1'b0; wdat = 3'd0;
    tick(3);
    t0 = cyc;
    at(1, 8'hFF, 8'h00, "R1 reset outputs low");
    tick(2);
    rst = 1'b0;
    tick(3);
    t0 = cyc;
    at(1, 8'hFF, TN, "R9 idle inverted copy high");
    tick(3);

    // both channels together, select 0 after reset (R1, R4, R6, R7)
    t0 = cyc;
    at(2,      D1|D2,             8'h00,        "R2 no pulse before third edge");
    at(3,      D1|D2|AN,          D1|D2,        "R2 discriminators rise");
    at(4,      AN|XO|L1|L2|TM|TN, AN|L1|L2|TN,  "R4 coincidence event, R5 quiet, R6 leds");
    at(5,      TM|TN,             TM,           "R7 R1 code 0 routes coincidence");
    at(SH + 2, D1|D2,             D1|D2,        "R2 R10 last shaped cycle");
    at(SH + 3, D1|D2|AN|XO,       AN,           "R2 R10 shaped pulse ends");
    at(EV + 3, AN,                AN,           "R4 R10 last event cycle");
    at(EV + 4, AN|TM,             TM,           "R4 event ends");
    at(EV + 5, TM|TN,             TN,           "R7 R9 timing follows event end");
    at(LD + 3, L1|L2,             L1|L2,        "R6 R10 last led cycle");
    at(LD + 4, L1|L2,             8'h00,        "R6 led ends");
    raw = 2'b11; tick(3); raw = 2'b00;
    tick(LD + 30);

    // single channel with re-trigger attempt, select 1 (R3, R5)
    wr(3'd1);
    tick(2);
    t0 = cyc;
    at(3,      D1|D2,       D1,     "R2 channel 1 alone");
    at(4,      AN|XO|L1|L2, XO|L1,  "R5 anti-coincidence event, R6");
    at(5,      TM,          TM,     "R7 code 1 routes anti-coincidence");
    at(8,      D1,          D1,     "R3 pulse held during second edge");
    at(SH + 2, D1,          D1,     "R3 original width kept");
    at(SH + 3, D1,          8'h00,  "R3 no extension by second edge");
    at(SH + 6, D1,          8'h00,  "R3 no new pulse");
    at(EV + 4, XO,          8'h00,  "R5 R10 event ends");
    at(LD + 4, L1,          8'h00,  "R6 led ends");
    raw = 2'b01; tick(3); raw = 2'b00; tick(2); raw = 2'b01; tick(10); raw = 2'b00;
    tick(LD + 20);

    // staggered overlap (R4)
    t0 = cyc;
    at(4, XO|AN, XO,  "R5 first channel alone");
    at(7, AN|D2, D2,  "R4 event waits for overlap");
    at(8, AN,    AN,  "R4 overlap starts event");
    raw = 2'b01; tick(4); raw = 2'b11; tick(3); raw = 2'b00;
    tick(LD + 30);

    // no overlap (R4)
    t0 = cyc;
    at(SH + 9,  AN|D2, D2,    "R4 disjoint pulses no coincidence");
    at(SH + 15, AN,    8'h00, "R4 still no coincidence");
    raw = 2'b01; tick(3); raw = 2'b00; tick(SH + 2); raw = 2'b10; tick(3); raw = 2'b00;
    tick(LD + 30);

    // routing of discriminators (R7)
    wr(3'd2);
    tick(2);
    t0 = cyc;
    at(4, TM, 8'h00, "R7 code 2 ignores channel 2");
    at(6, TM, 8'h00, "R7 code 2 ignores channel 2");
    raw = 2'b10; tick(3); raw = 2'b00;
    tick(LD + 30);
    t0 = cyc;
    at(3,      TM, 8'h00, "R7 code 2 one cycle behind");
    at(4,      TM, TM,    "R7 code 2 routes channel 1");
    at(SH + 3, TM, TM,    "R7 code 2 width");
    at(SH + 4, TM, 8'h00, "R7 code 2 ends");
    raw = 2'b01; tick(3); raw = 2'b00;
    tick(LD + 30);
    wr(3'd3);
    tick(2);
    t0 = cyc;
    at(4,      TM, TM,    "R7 code 3 routes channel 2");
    at(SH + 4, TM, 8'h00, "R7 code 3 ends");
    raw = 2'b10; tick(3); raw = 2'b00;
    tick(LD + 30);

    // timepulse and unused codes (R7, R8, R9)
    wr(3'd4);
    tick(2);
    t0 = cyc;
    at(2, TM,    8'h00, "R7 timepulse still in synchroniser");
    at(3, TM|TN, TM,    "R7 code 4 routes timepulse, R9");
    tp = 1'b1;
    tick(6);
    t0 = cyc;
    at(1, TM,    TM, "R8 old code holds one more cycle");
    at(2, TM|TN, TN, "R8 code 6 drives low, R9");
    wr(3'd6);
    tick(4);
    t0 = cyc;
    at(2, TM|TN, TN, "R8 code 5 drives low");
    wr(3'd5);
    tick(4);
    t0 = cyc;
    at(2, TM|TN, TN, "R8 code 7 drives low");
    wr(3'd7);
    tick(4);
    t0 = cyc;
    at(2, TM|TN, TM, "R8 back to code 4");
    wr(3'd4);
    tick(4);
    tp = 1'b0;
    tick(10);

    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R1 queue not drained: actual %0d items expected 0", q.size());
    end
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog expired: actual hung expected finish");
      finish_run();
    end
  end
endmodule